// File: doc/BRIEF.md
# Instruction Loop Buffer

This block is the fetch stage of a simple in-order core. It owns the fetch program counter, requests instructions from an instruction memory over a valid/ready request channel and a valid/ready response channel with any latency, and presents one instruction at a time to decode together with its address. Each word that comes back from memory is appended to a small circular store that always holds one contiguous run of the most recently fetched addresses.

When the execute stage redirects fetch with a taken branch, the target is compared against the stored run. If the target is inside the run, the instruction is served from the store in the next cycle without any memory traffic. Sequential fetches that follow also come from the store for as long as they stay inside the run. A tight loop that fits in the store therefore reaches memory only on its first pass. If the target is outside the run, the store is emptied, its base becomes the target, and fetch restarts from memory.

The controller has three states. `S_REQ` drives a memory request for the current address. `S_WAIT` waits for the response. `S_OUT` presents an instruction to decode. The named transitions are as follows. T_GRANT (`S_REQ`→`S_WAIT`) occurs when the request is accepted. T_RESP (`S_WAIT`→`S_OUT`) occurs when the response arrives; the word is appended to the store. T_HIT (`S_OUT`→`S_OUT`) is a branch whose target lies in the run. T_MISS (`S_OUT`→`S_REQ`) is a branch whose target lies outside the run; the store is cleared. T_SEQ_BUF (`S_OUT`→`S_OUT`) occurs when decode accepts and the next address lies in the run. T_SEQ_MEM (`S_OUT`→`S_REQ`) occurs when decode accepts and the next address is past the run.

Top module: `loop_fetch_buf`

## Requirements
- R1: During and right after reset, `insn_valid` is 0 and a memory request for address `RESET_PC` (default 0x0100) is driven.
- R2: A memory request keeps `mem_req_valid` high with a stable address until `mem_req_ready`. Each fetch from memory issues exactly one request. `mem_rsp_ready` is high only while a response is awaited, and never together with `insn_valid` or `mem_req_valid`.
- R3: When decode accepts the instruction at address A (`dec_ready` with `insn_valid`, no branch), the next instruction presented is at A+1. Every presented instruction equals the memory word at its address.
- R4: While `insn_valid` is high and neither `dec_ready` nor `br_valid` is asserted, `insn_addr` and `insn_data` hold.
- R5: A branch whose target T satisfies base ≤ T < base+count (modulo 2^ADDR_W) is a hit. In the cycle after the branch, the instruction at T is presented and no memory request is made.
- R6: After a hit, sequential addresses inside the stored run are served from the store without memory requests. The first address past the run is fetched from memory and appended.
- R7: A branch whose target is outside the run, including exactly base+count and base−1, empties the store, sets its base to the target, and drives a memory request for the target in the next cycle.
- R8: The store holds at most DEPTH (default 8) entries. Appending to a full store drops the oldest address, so the base advances by one. A target at the new base hits, and a target at the dropped address misses.
- R9: `br_valid` has no effect while `insn_valid` is low.
- R10: When `br_valid` and `dec_ready` are both high with `insn_valid`, the branch takes priority and the sequential advance is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | Taken-branch redirect strobe |
| br_target | input | ADDR_W | Branch target address |
| dec_ready | input | 1 | Decode accepts the presented instruction |
| insn_valid | output | 1 | An instruction is presented to decode |
| insn_addr | output | ADDR_W | Address of the presented instruction |
| insn_data | output | INSN_W | Presented instruction word |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_addr | output | ADDR_W | Memory read address |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Memory returns a word |
| mem_rsp_ready | output | 1 | Fetch stage awaits a response |
| mem_rsp_data | input | INSN_W | Returned instruction word |

## Verification
A hit, whether from a branch or from a sequential advance inside the run, is due at the first sampling point after the clock edge that took the stimulus. A miss or a step past the run shows a request on the memory port at that same point. A memory fetch presents its instruction one edge after the response edge. The bench drives every stimulus for exactly one cycle from a falling edge and samples at the next falling edge, or waits for `insn_valid` when memory latency is involved. Request counts are compared only where no grant can coincide with the check, so that the absence of memory traffic on hits is observed directly.

// File: rtl/lbuf_pkg.sv
package lbuf_pkg;
    typedef enum logic [1:0] {
        S_REQ  = 2'd0,
        S_WAIT = 2'd1,
        S_OUT  = 2'd2
    } fetch_st_t;
endpackage

// File: rtl/lbuf_store.sv
// Circular store for one contiguous run of fetched words, with
// NPORT combinational address lookups against that run.
module lbuf_store #(
    parameter int ADDR_W = 16,
    parameter int INSN_W = 32,
    parameter int DEPTH  = 8,
    parameter int NPORT  = 2,
    parameter logic [ADDR_W-1:0] RESET_PC = 'h0100,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         app_en,
    input  logic [INSN_W-1:0]            app_data,
    input  logic                         clr_en,
    input  logic [ADDR_W-1:0]            clr_base,
    input  logic [NPORT-1:0][ADDR_W-1:0] rd_addr,
    output logic [NPORT-1:0]             rd_hit,
    output logic [NPORT-1:0][INSN_W-1:0] rd_data,
    output logic [CNT_W-1:0]             cnt
);
    logic [INSN_W-1:0] mem_q [DEPTH];
    logic [IDX_W-1:0]  head_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] base_q;
    logic              full;
    logic [IDX_W-1:0]  wr_idx;

    assign full   = (cnt_q == CNT_W'(DEPTH));
    assign wr_idx = head_q + cnt_q[IDX_W-1:0];
    assign cnt    = cnt_q;

    always_ff @(posedge clk) begin
        if (app_en) mem_q[wr_idx] <= app_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            cnt_q  <= '0;
            base_q <= RESET_PC;
        end else if (clr_en) begin
            head_q <= '0;
            cnt_q  <= '0;
            base_q <= clr_base;
        end else if (app_en) begin
            if (full) begin
                head_q <= head_q + 1'b1;
                base_q <= base_q + 1'b1;
            end else begin
                cnt_q  <= cnt_q + 1'b1;
            end
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_look
        logic [ADDR_W-1:0] off;
        logic [IDX_W-1:0]  rd_idx;
        assign off        = rd_addr[p] - base_q;
        assign rd_idx     = head_q + off[IDX_W-1:0];
        assign rd_hit[p]  = (off < ADDR_W'(cnt_q));
        assign rd_data[p] = mem_q[rd_idx];
    end
endmodule

// File: rtl/lbuf_ctrl.sv
// Fetch controller: program counter, presented word and state machine.
module lbuf_ctrl
    import lbuf_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int INSN_W = 32,
    parameter logic [ADDR_W-1:0] RESET_PC = 'h0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_valid,
    input  logic [ADDR_W-1:0] br_target,
    input  logic              dec_ready,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [INSN_W-1:0] mem_rsp_data,
    input  logic              tgt_hit,
    input  logic [INSN_W-1:0] tgt_data,
    input  logic              nxt_hit,
    input  logic [INSN_W-1:0] nxt_data,
    output logic [ADDR_W-1:0] pc,
    output logic              app_en,
    output logic              clr_en,
    output logic              insn_valid,
    output logic [INSN_W-1:0] insn_data,
    output logic              mem_req_valid,
    output logic              mem_rsp_ready
);
    fetch_st_t         state_q, state_d;
    logic [ADDR_W-1:0] pc_q, pc_d;
    logic [INSN_W-1:0] insn_q, insn_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_REQ;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= RESET_PC;
            insn_q <= '0;
        end else begin
            pc_q   <= pc_d;
            insn_q <= insn_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        insn_d  = insn_q;
        app_en  = 1'b0;
        clr_en  = 1'b0;
        unique case (state_q)
            S_REQ: begin
                if (mem_req_ready) state_d = S_WAIT;           // T_GRANT
            end
            S_WAIT: begin
                if (mem_rsp_valid) begin                       // T_RESP
                    app_en  = 1'b1;
                    insn_d  = mem_rsp_data;
                    state_d = S_OUT;
                end
            end
            S_OUT: begin
                if (br_valid) begin
                    pc_d = br_target;
                    if (tgt_hit) begin                         // T_HIT
                        insn_d = tgt_data;
                    end else begin                             // T_MISS
                        clr_en  = 1'b1;
                        state_d = S_REQ;
                    end
                end else if (dec_ready) begin
                    pc_d = pc_q + 1'b1;
                    if (nxt_hit) insn_d  = nxt_data;           // T_SEQ_BUF
                    else         state_d = S_REQ;              // T_SEQ_MEM
                end
            end
            default: state_d = S_REQ;
        endcase
    end

    // outputs
    always_comb begin
        pc            = pc_q;
        insn_data     = insn_q;
        insn_valid    = (state_q == S_OUT);
        mem_req_valid = (state_q == S_REQ);
        mem_rsp_ready = (state_q == S_WAIT);
    end
endmodule

// File: rtl/loop_fetch_buf.sv
module loop_fetch_buf #(
    parameter int ADDR_W = 16,
    parameter int INSN_W = 32,
    parameter int DEPTH  = 8,
    parameter logic [ADDR_W-1:0] RESET_PC = 'h0100,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_valid,
    input  logic [ADDR_W-1:0] br_target,
    input  logic              dec_ready,
    output logic              insn_valid,
    output logic [ADDR_W-1:0] insn_addr,
    output logic [INSN_W-1:0] insn_data,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    output logic              mem_rsp_ready,
    input  logic [INSN_W-1:0] mem_rsp_data
);
    logic [ADDR_W-1:0]         pc;
    logic                      app_en, clr_en;
    logic [1:0][ADDR_W-1:0]    look_addr;
    logic [1:0]                look_hit;
    logic [1:0][INSN_W-1:0]    look_data;
    logic [CNT_W-1:0]          buf_cnt;

    assign look_addr[0] = br_target;
    assign look_addr[1] = pc + 1'b1;
    assign insn_addr    = pc;
    assign mem_req_addr = pc;

    lbuf_store #(
        .ADDR_W(ADDR_W), .INSN_W(INSN_W), .DEPTH(DEPTH),
        .NPORT(2), .RESET_PC(RESET_PC)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .app_en(app_en), .app_data(mem_rsp_data),
        .clr_en(clr_en), .clr_base(br_target),
        .rd_addr(look_addr), .rd_hit(look_hit), .rd_data(look_data),
        .cnt(buf_cnt)
    );

    lbuf_ctrl #(
        .ADDR_W(ADDR_W), .INSN_W(INSN_W), .RESET_PC(RESET_PC)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .br_valid(br_valid), .br_target(br_target), .dec_ready(dec_ready),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data),
        .tgt_hit(look_hit[0]), .tgt_data(look_data[0]),
        .nxt_hit(look_hit[1]), .nxt_data(look_data[1]),
        .pc(pc), .app_en(app_en), .clr_en(clr_en),
        .insn_valid(insn_valid), .insn_data(insn_data),
        .mem_req_valid(mem_req_valid), .mem_rsp_ready(mem_rsp_ready)
    );
endmodule

// File: rtl/lbuf_checker.sv
module lbuf_checker #(
    parameter int ADDR_W = 16,
    parameter int INSN_W = 32,
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              br_valid,
    input logic [ADDR_W-1:0] br_target,
    input logic              dec_ready,
    input logic              insn_valid,
    input logic [ADDR_W-1:0] insn_addr,
    input logic [INSN_W-1:0] insn_data,
    input logic              mem_req_valid,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_req_ready,
    input logic              mem_rsp_ready,
    input logic [CNT_W-1:0]  buf_cnt
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R2

    AST_RSP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_ready |-> !insn_valid && !mem_req_valid); // R2

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid && !dec_ready && !br_valid |=>
            insn_valid && $stable(insn_addr) && $stable(insn_data)); // R4

    AST_SEQ_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid && dec_ready && !br_valid |=>
            (insn_valid && insn_addr == $past(insn_addr) + 1'b1) ||
            (mem_req_valid && mem_req_addr == $past(insn_addr) + 1'b1)); // R3

    AST_BR_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid && br_valid |=>
            (insn_valid && !mem_req_valid && insn_addr == $past(br_target)) ||
            (mem_req_valid && mem_req_addr == $past(br_target))); // R5

    AST_CNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        buf_cnt <= CNT_W'(DEPTH)); // R8
endmodule

bind loop_fetch_buf lbuf_checker #(
    .ADDR_W(ADDR_W), .INSN_W(INSN_W), .DEPTH(DEPTH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_target(br_target),
    .dec_ready(dec_ready), .insn_valid(insn_valid), .insn_addr(insn_addr),
    .insn_data(insn_data), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready),
    .mem_rsp_ready(mem_rsp_ready), .buf_cnt(buf_cnt)
);

// File: tb/sim_loop_fetch_buf.sv
`timescale 1ns/1ps
module sim_loop_fetch_buf;
    localparam int AW = 16;
    localparam int IW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          br_valid = 1'b0;
    logic [AW-1:0] br_target = '0;
    logic          dec_ready = 1'b0;
    logic          insn_valid;
    logic [AW-1:0] insn_addr;
    logic [IW-1:0] insn_data;
    logic          mem_req_valid;
    logic [AW-1:0] mem_req_addr;
    logic          mem_req_ready = 1'b0;
    logic          mem_rsp_valid = 1'b0;
    logic          mem_rsp_ready;
    logic [IW-1:0] mem_rsp_data = '0;

    int n_chk = 0;
    int n_bad = 0;
    int req_cnt = 0;
    logic [AW-1:0] last_req = '0;
    int gnt_dly = 0;
    int rsp_dly = 0;

    always #2.5 clk = ~clk;

    loop_fetch_buf u0 (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_target(br_target),
        .dec_ready(dec_ready), .insn_valid(insn_valid), .insn_addr(insn_addr),
        .insn_data(insn_data), .mem_req_valid(mem_req_valid),
        .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
        .mem_rsp_data(mem_rsp_data)
    );

    function automatic logic [IW-1:0] word_at(logic [AW-1:0] a);
        return {~a, a};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [IW-1:0] act,
                       input logic [IW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // memory model
    initial begin
        logic [AW-1:0] a;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                repeat (gnt_dly) @(negedge clk);
                mem_req_ready = 1'b1;
                a = mem_req_addr;
                req_cnt++;
                last_req = a;
                @(negedge clk);
                mem_req_ready = 1'b0;
                repeat (rsp_dly) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = word_at(a);
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end
        end
    end

    task automatic wait_valid();
        int n = 0;
        while (!insn_valid && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic take(input logic [AW-1:0] a, input string tag);
        wait_valid();
        chk(insn_valid && insn_addr == a, {tag, " addr"}, IW'(insn_addr), IW'(a));
        chk(insn_data == word_at(a), {tag, " data"}, insn_data, word_at(a));
        dec_ready = 1'b1;
        @(negedge clk);
        dec_ready = 1'b0;
    endtask

    task automatic branch(input logic [AW-1:0] t);
        wait_valid();
        br_valid  = 1'b1;
        br_target = t;
        @(negedge clk);
        br_valid  = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(!insn_valid, "R1 insn_valid in reset", IW'(insn_valid), 0);
        chk(mem_req_valid && mem_req_addr == 16'h0100, "R1 reset request",
            IW'(mem_req_addr), 32'h0100);
        rst_n = 1'b1;
    endtask

    task automatic t_fill();
        gnt_dly = 3; rsp_dly = 2;
        wait_valid();
        chk(req_cnt == 1, "R2 single request for 0x100", req_cnt, 1);
        for (int i = 0; i < 6; i++) begin
            if (i == 3) begin gnt_dly = 0; rsp_dly = 0; end
            take(AW'(16'h0100 + i), "R3 sequential fill");
        end
        wait_valid();
        chk(req_cnt == 7, "R2 one request per fetch", req_cnt, 7);
    endtask

    task automatic t_stall();
        logic [AW-1:0] a0;
        logic [IW-1:0] d0;
        wait_valid();
        a0 = insn_addr; d0 = insn_data;
        repeat (3) @(negedge clk);
        chk(insn_valid && insn_addr == a0 && insn_data == d0, "R4 hold while stalled",
            insn_data, d0);
        take(16'h0106, "R4 stalled word");
    endtask

    task automatic t_loop();
        wait_valid();
        chk(insn_addr == 16'h0107, "R6 run end", IW'(insn_addr), 32'h0107);
        branch(16'h0102);
        chk(insn_valid && insn_addr == 16'h0102 && !mem_req_valid, "R5 hit next cycle",
            IW'(insn_addr), 32'h0102);
        chk(req_cnt == 8, "R5 no request on hit", req_cnt, 8);
        for (int i = 2; i < 7; i++) take(AW'(16'h0100 + i), "R6 loop from buffer");
        chk(insn_valid && req_cnt == 8, "R6 no request inside run", req_cnt, 8);
        take(16'h0107, "R6 last buffered word");
        wait_valid();
        chk(req_cnt == 9 && last_req == 16'h0108, "R6 past run goes to memory",
            IW'(last_req), 32'h0108);
        chk(insn_addr == 16'h0108 && insn_data == word_at(16'h0108), "R6 appended word",
            insn_data, word_at(16'h0108));
    endtask

    task automatic t_capacity();
        branch(16'h0101);
        chk(insn_valid && insn_addr == 16'h0101 && req_cnt == 9, "R8 oldest kept hits",
            IW'(insn_addr), 32'h0101);
        chk(insn_data == word_at(16'h0101), "R8 oldest kept data", insn_data,
            word_at(16'h0101));
        branch(16'h0100);
        chk(mem_req_valid && mem_req_addr == 16'h0100, "R8 dropped address misses",
            IW'(mem_req_addr), 32'h0100);
        wait_valid();
        chk(insn_addr == 16'h0100 && req_cnt == 10, "R8 refetch after drop", req_cnt, 10);
    endtask

    task automatic t_miss();
        branch(16'h0101);
        chk(mem_req_valid && mem_req_addr == 16'h0101, "R7 base+count misses",
            IW'(mem_req_addr), 32'h0101);
        take(16'h0101, "R7 miss target");
        chk(req_cnt == 11, "R7 miss request count", req_cnt, 11);
        wait_valid();
        branch(16'h0101);
        chk(insn_valid && insn_addr == 16'h0101 && req_cnt == 12, "R7 new run holds target",
            IW'(insn_addr), 32'h0101);
        branch(16'h0100);
        chk(mem_req_valid && mem_req_addr == 16'h0100, "R7 below base misses",
            IW'(mem_req_addr), 32'h0100);
        wait_valid();
        chk(insn_addr == 16'h0100 && req_cnt == 13, "R7 refetch below base", req_cnt, 13);
    endtask

    task automatic t_priority();
        wait_valid();
        br_valid = 1'b1; br_target = 16'h0100; dec_ready = 1'b1;
        @(negedge clk);
        br_valid = 1'b0; dec_ready = 1'b0;
        chk(insn_valid && insn_addr == 16'h0100 && !mem_req_valid,
            "R10 branch beats advance", IW'(insn_addr), 32'h0100);
        chk(req_cnt == 13, "R10 no request", req_cnt, 13);
    endtask

    task automatic t_ignore();
        rsp_dly = 4;
        take(16'h0100, "R9 before ignore");
        br_valid = 1'b1; br_target = 16'h0100;
        repeat (2) @(negedge clk);
        br_valid = 1'b0;
        wait_valid();
        chk(insn_addr == 16'h0101 && insn_data == word_at(16'h0101),
            "R9 branch ignored while idle", IW'(insn_addr), 32'h0101);
        chk(req_cnt == 14 && last_req == 16'h0101, "R9 request unchanged",
            IW'(last_req), 32'h0101);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired act=running exp=done");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_fill();
        t_stall();
        t_loop();
        t_capacity();
        t_miss();
        t_priority();
        t_ignore();
        repeat (4) @(negedge clk);
        summary();
        $finish;
    end
endmodule